// File: doc/BRIEF.md
# Register Bus Width Downsizer

The block connects a wide register-access bus on its upstream (RX) side to a narrower register bus on its downstream (TX) side. An upstream access covers one wide word. The block cuts that word into narrow chunks and sends one downstream access for each chunk that has at least one enabled byte. Chunks whose byte enables are all low produce no downstream traffic.

For reads, the narrow data words that come back are placed in their byte lanes of one wide response word. Disabled bytes read as zero. The block handles one upstream access at a time. Its upstream ready output stays low until the whole access has finished, so the block is a drop-in adapter between a wide master and a narrow register file.

Addresses are byte addresses. Each bus uses addresses aligned to its own word size. A write takes priority if both request strobes are high together.

Top module: `bus_narrower`

## Requirements
- R1: After reset `up_ready` is high, `up_rvalid` is low, and neither `dn_wr` nor `dn_rd` is asserted.
- R2: An accepted write produces one `dn_wr` access for every chunk with a nonzero byte-enable slice. Chunk k carries bits [k*DN_W +: DN_W] of the write data and bits [k*DN_W/8 +: DN_W/8] of the byte enables. Chunks are issued in ascending k.
- R3: A chunk whose byte-enable slice is all zero is skipped. `dn_be` is never zero while a downstream request is asserted.
- R4: The address of chunk k is the upstream address with its low log2(UP_W/8) bits cleared, plus k*DN_W/8. Every downstream address is therefore aligned to DN_W/8 bytes.
- R5: `up_ready` is low from the cycle after acceptance until the access completes. With `dn_ready` held high and an immediate read response, it stays low for exactly one cycle per issued write chunk, or two cycles per issued read chunk.
- R6: While a downstream request is asserted and `dn_ready` is low, `dn_addr`, `dn_be`, `dn_wdata`, `dn_wr` and `dn_rd` hold their values.
- R7: `dn_wr` and `dn_rd` are never high together. During a read, the next chunk is not requested until `dn_rvalid` has returned data for the current one.
- R8: Returned data for chunk k lands in lane k of `up_rdata`, and bytes whose upstream byte enable was low read as zero. `up_rvalid` is high for exactly one cycle, in the cycle after the last chunk's data arrives, and `up_ready` is high in that same cycle.
- R9: A write with all byte enables low is accepted with no downstream traffic, and `up_ready` stays high.
- R10: A read with all byte enables low is accepted with no downstream traffic, and `up_rvalid` pulses in the next cycle with an all-zero `up_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_addr | input | ADDR_W | Upstream byte address |
| up_wdata | input | UP_W | Upstream write data |
| up_be | input | UP_W/8 | Upstream byte enables |
| up_wr | input | 1 | Upstream write request |
| up_rd | input | 1 | Upstream read request |
| up_ready | output | 1 | Block can take a request this cycle |
| up_rdata | output | UP_W | Assembled read data |
| up_rvalid | output | 1 | Read data valid, one-cycle pulse |
| dn_addr | output | ADDR_W | Downstream byte address |
| dn_wdata | output | DN_W | Downstream write data |
| dn_be | output | DN_W/8 | Downstream byte enables |
| dn_wr | output | 1 | Downstream write request |
| dn_rd | output | 1 | Downstream read request |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_rdata | input | DN_W | Downstream read data |
| dn_rvalid | input | 1 | Downstream read data valid |

## Verification
Assertions check on every cycle that:
- a downstream request never carries empty byte enables or a misaligned address;
- a stalled request stays frozen;
- read and write strobes are exclusive;
- the upstream side is busy whenever downstream traffic runs;
- all-zero accesses finish in one cycle.

Only the directed scenarios can show that the right chunks appear in the right order with the right slices, that returned data ends up in the correct lanes with disabled bytes zeroed, and that the busy time matches the chunk count.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ISSUE     = 2'd1,
        ST_WAIT_READ = 2'd2
    } nar_state_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } nar_op_e;

    localparam int unsigned BYTE_W = 8;

    function automatic bit width_ok(input int unsigned w);
        return (w >= BYTE_W) && ((w & (w - 1)) == 0);
    endfunction

endpackage

// File: rtl/chunk_mask_gen.sv
module chunk_mask_gen #(
    parameter int unsigned CHUNKS     = 4,
    parameter int unsigned LANE_BYTES = 2
) (
    input  logic [CHUNKS*LANE_BYTES-1:0] be,
    output logic [CHUNKS-1:0]            live
);
    for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
        assign live[c] = |be[c*LANE_BYTES +: LANE_BYTES];
    end
endmodule

// File: rtl/chunk_seeker.sv
module chunk_seeker #(
    parameter int unsigned CHUNKS = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [CHUNKS-1:0] live,
    input  logic [IDX_W:0]    start,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Lowest live chunk at or above start; scanning downward leaves the lowest hit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = CHUNKS - 1; j >= 0; j--) begin
            if (live[j] && (j >= int'(start))) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/read_gather.sv
module read_gather #(
    parameter int unsigned CHUNKS = 4,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     load,
    input  logic [IDX_W-1:0]         lane,
    input  logic [LANE_W/8-1:0]      lane_be,
    input  logic [LANE_W-1:0]        lane_data,
    output logic [CHUNKS*LANE_W-1:0] word
);
    localparam int unsigned LB = LANE_W / 8;

    logic [LANE_W-1:0] masked;

    always_comb begin
        for (int b = 0; b < LB; b++) begin
            masked[b*8 +: 8] = lane_be[b] ? lane_data[b*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (load) begin
            for (int c = 0; c < CHUNKS; c++) begin
                if (lane == IDX_W'(c)) begin
                    word[c*LANE_W +: LANE_W] <= masked;
                end
            end
        end
    end
endmodule

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
    import narrow_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned UP_W   = 64,
    parameter int unsigned DN_W   = 16,
    localparam int unsigned UB     = UP_W / 8,
    localparam int unsigned DB     = DN_W / 8,
    localparam int unsigned CHUNKS = UP_W / DN_W,
    localparam int unsigned IDX_W  = $clog2(CHUNKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [UP_W-1:0]   up_wdata,
    input  logic [UB-1:0]     up_be,
    input  logic              up_wr,
    input  logic              up_rd,
    output logic              up_ready,
    output logic              up_rvalid,
    input  logic              first_found,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic              next_found,
    input  logic [IDX_W-1:0]  next_idx,
    output logic [UB-1:0]     be_hold,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              gather_clear,
    output logic              gather_load,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DN_W-1:0]   dn_wdata,
    output logic [DB-1:0]     dn_be,
    output logic              dn_wr,
    output logic              dn_rd,
    input  logic              dn_ready,
    input  logic              dn_rvalid
);
    localparam int unsigned DB_LOG = $clog2(DB);
    localparam logic [ADDR_W-1:0] UP_ALIGN = ~ADDR_W'(UB - 1);

    nar_state_e        state_q;
    nar_op_e           op_q;
    nar_op_e           op_in;
    logic [ADDR_W-1:0] base_q;
    logic [UP_W-1:0]   wdata_q;
    logic [UB-1:0]     be_q;
    logic [IDX_W-1:0]  idx_q;
    logic              rvalid_q;
    logic              accept;

    assign up_ready  = (state_q == ST_IDLE);
    assign accept    = up_ready && (up_wr || up_rd);
    assign op_in     = up_wr ? OP_WRITE : OP_READ;
    assign up_rvalid = rvalid_q;

    assign be_hold      = be_q;
    assign cur_idx      = idx_q;
    assign gather_clear = accept;
    assign gather_load  = (state_q == ST_WAIT_READ) && dn_rvalid;

    assign dn_wr    = (state_q == ST_ISSUE) && (op_q == OP_WRITE);
    assign dn_rd    = (state_q == ST_ISSUE) && (op_q == OP_READ);
    assign dn_addr  = base_q + (ADDR_W'(idx_q) << DB_LOG);
    assign dn_be    = be_q[idx_q*DB +: DB];
    assign dn_wdata = wdata_q[idx_q*DN_W +: DN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_WRITE;
            base_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            idx_q    <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        base_q  <= up_addr & UP_ALIGN;
                        wdata_q <= up_wdata;
                        be_q    <= up_be;
                        op_q    <= op_in;
                        idx_q   <= first_idx;
                        if (first_found) begin
                            state_q <= ST_ISSUE;
                        end else if (op_in == OP_READ) begin
                            rvalid_q <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (dn_ready) begin
                        if (op_q == OP_READ) begin
                            state_q <= ST_WAIT_READ;
                        end else if (next_found) begin
                            idx_q <= next_idx;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT_READ: begin
                    if (dn_rvalid) begin
                        if (next_found) begin
                            idx_q   <= next_idx;
                            state_q <= ST_ISSUE;
                        end else begin
                            state_q  <= ST_IDLE;
                            rvalid_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_narrower.sv
module bus_narrower
    import narrow_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned UP_W   = 64,
    parameter int unsigned DN_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   up_addr,
    input  logic [UP_W-1:0]     up_wdata,
    input  logic [UP_W/8-1:0]   up_be,
    input  logic                up_wr,
    input  logic                up_rd,
    output logic                up_ready,
    output logic [UP_W-1:0]     up_rdata,
    output logic                up_rvalid,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic [DN_W-1:0]     dn_wdata,
    output logic [DN_W/8-1:0]   dn_be,
    output logic                dn_wr,
    output logic                dn_rd,
    input  logic                dn_ready,
    input  logic [DN_W-1:0]     dn_rdata,
    input  logic                dn_rvalid
);
    localparam int unsigned UB     = UP_W / 8;
    localparam int unsigned DB     = DN_W / 8;
    localparam int unsigned CHUNKS = UP_W / DN_W;
    localparam int unsigned IDX_W  = $clog2(CHUNKS);

    if (!width_ok(UP_W) || !width_ok(DN_W) || (UP_W <= DN_W)) begin : g_bad_widths
        $error("bus_narrower: widths must be powers of two >= 8 with UP_W > DN_W");
    end

    logic [CHUNKS-1:0] live_in;
    logic [CHUNKS-1:0] live_hold;
    logic [UB-1:0]     be_hold;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W:0]    next_start;
    logic              first_found;
    logic [IDX_W-1:0]  first_idx;
    logic              next_found;
    logic [IDX_W-1:0]  next_idx;
    logic              gather_clear;
    logic              gather_load;

    assign next_start = {1'b0, cur_idx} + 1'b1;

    chunk_mask_gen #(.CHUNKS(CHUNKS), .LANE_BYTES(DB)) i_mask_in (
        .be   (up_be),
        .live (live_in)
    );

    chunk_mask_gen #(.CHUNKS(CHUNKS), .LANE_BYTES(DB)) i_mask_hold (
        .be   (be_hold),
        .live (live_hold)
    );

    chunk_seeker #(.CHUNKS(CHUNKS), .IDX_W(IDX_W)) i_seek_first (
        .live  (live_in),
        .start ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    chunk_seeker #(.CHUNKS(CHUNKS), .IDX_W(IDX_W)) i_seek_next (
        .live  (live_hold),
        .start (next_start),
        .found (next_found),
        .idx   (next_idx)
    );

    narrow_ctrl #(.ADDR_W(ADDR_W), .UP_W(UP_W), .DN_W(DN_W)) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .up_addr      (up_addr),
        .up_wdata     (up_wdata),
        .up_be        (up_be),
        .up_wr        (up_wr),
        .up_rd        (up_rd),
        .up_ready     (up_ready),
        .up_rvalid    (up_rvalid),
        .first_found  (first_found),
        .first_idx    (first_idx),
        .next_found   (next_found),
        .next_idx     (next_idx),
        .be_hold      (be_hold),
        .cur_idx      (cur_idx),
        .gather_clear (gather_clear),
        .gather_load  (gather_load),
        .dn_addr      (dn_addr),
        .dn_wdata     (dn_wdata),
        .dn_be        (dn_be),
        .dn_wr        (dn_wr),
        .dn_rd        (dn_rd),
        .dn_ready     (dn_ready),
        .dn_rvalid    (dn_rvalid)
    );

    read_gather #(.CHUNKS(CHUNKS), .LANE_W(DN_W), .IDX_W(IDX_W)) i_gather (
        .clk       (clk),
        .rst       (rst),
        .clear     (gather_clear),
        .load      (gather_load),
        .lane      (cur_idx),
        .lane_be   (dn_be),
        .lane_data (dn_rdata),
        .word      (up_rdata)
    );
endmodule

// File: rtl/bus_narrower_chk.sv
module bus_narrower_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned UP_W   = 64,
    parameter int unsigned DN_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [UP_W/8-1:0] up_be,
    input logic              up_wr,
    input logic              up_rd,
    input logic              up_ready,
    input logic [UP_W-1:0]   up_rdata,
    input logic              up_rvalid,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DN_W-1:0]   dn_wdata,
    input logic [DN_W/8-1:0] dn_be,
    input logic              dn_wr,
    input logic              dn_rd,
    input logic              dn_ready
);
    localparam logic [ADDR_W-1:0] DN_LOW = ADDR_W'(DN_W / 8 - 1);

    a_r3_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        (dn_wr || dn_rd) |-> (dn_be != '0));

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        (dn_wr || dn_rd) |-> ((dn_addr & DN_LOW) == '0));

    a_r5_busy_while_issuing: assert property (@(posedge clk) disable iff (rst)
        (dn_wr || dn_rd) |-> !up_ready);

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        ((dn_wr || dn_rd) && !dn_ready) |=>
            ($stable(dn_addr) && $stable(dn_be) && $stable(dn_wdata)
             && $stable(dn_wr) && $stable(dn_rd)));

    a_r7_exclusive_kind: assert property (@(posedge clk) disable iff (rst)
        !(dn_wr && dn_rd));

    a_r8_rvalid_when_free: assert property (@(posedge clk) disable iff (rst)
        up_rvalid |-> up_ready);

    a_r9_empty_write: assert property (@(posedge clk) disable iff (rst)
        (up_ready && up_wr && (up_be == '0)) |=> (up_ready && !dn_wr && !dn_rd));

    a_r10_empty_read: assert property (@(posedge clk) disable iff (rst)
        (up_ready && up_rd && !up_wr && (up_be == '0)) |=>
            (up_rvalid && (up_rdata == '0) && !dn_rd));
endmodule

bind bus_narrower bus_narrower_chk #(
    .ADDR_W (ADDR_W),
    .UP_W   (UP_W),
    .DN_W   (DN_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .up_be     (up_be),
    .up_wr     (up_wr),
    .up_rd     (up_rd),
    .up_ready  (up_ready),
    .up_rdata  (up_rdata),
    .up_rvalid (up_rvalid),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .dn_be     (dn_be),
    .dn_wr     (dn_wr),
    .dn_rd     (dn_rd),
    .dn_ready  (dn_ready)
);

// File: tb/test_bus_narrower.sv
`timescale 1ns/1ps
module test_bus_narrower;
    localparam int AW = 32, UW = 64, DW = 16, UB = 8, DB = 2, NCH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] up_addr = '0;
    logic [UW-1:0] up_wdata = '0;
    logic [UB-1:0] up_be = '0;
    logic          up_wr = 1'b0, up_rd = 1'b0;
    wire           up_ready;
    wire  [UW-1:0] up_rdata;
    wire           up_rvalid;
    wire  [AW-1:0] dn_addr;
    wire  [DW-1:0] dn_wdata;
    wire  [DB-1:0] dn_be;
    wire           dn_wr, dn_rd;
    logic          dn_ready = 1'b1;
    logic [DW-1:0] dn_rdata = '0;
    logic          dn_rvalid = 1'b0;

    always #10 clk = ~clk;

    bus_narrower #(.ADDR_W(AW), .UP_W(UW), .DN_W(DW)) i_bus_narrower (
        .clk(clk), .rst(rst),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_be(up_be),
        .up_wr(up_wr), .up_rd(up_rd), .up_ready(up_ready),
        .up_rdata(up_rdata), .up_rvalid(up_rvalid),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_be(dn_be),
        .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_ready(dn_ready),
        .dn_rdata(dn_rdata), .dn_rvalid(dn_rvalid)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] resp(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h29};
    endfunction

    function automatic logic [UW-1:0] exp_rd(input logic [AW-1:0] addr, input logic [UB-1:0] be);
        logic [UW-1:0]  w = '0;
        logic [AW-1:0]  base = addr & ~AW'(UB - 1);
        for (int i = 0; i < UB; i++) begin
            if (be[i]) begin
                logic [DW-1:0] r = resp(base + AW'((i / DB) * DB));
                w[i*8 +: 8] = r[(i % DB)*8 +: 8];
            end
        end
        return w;
    endfunction

    // Downstream responder and monitor, all at the falling edge.
    bit            slow = 1'b0;
    int            log_n = 0;
    logic [AW-1:0] log_addr [16];
    logic [DB-1:0] log_be   [16];
    logic [DW-1:0] log_data [16];
    bit            log_wr   [16];
    bit            rd_pend = 1'b0;
    int            rd_wait = 0;
    logic [AW-1:0] rd_addr = '0;
    bit            prev_stall = 1'b0;
    logic [51:0]   prev_req = '0;
    int            hold_err = 0, both_err = 0;

    always @(negedge clk) begin
        dn_rvalid = 1'b0;
        dn_rdata  = 16'h5A5A;
        if (rd_pend) begin
            if (rd_wait == 0) begin
                dn_rvalid = 1'b1;
                dn_rdata  = resp(rd_addr);
                rd_pend   = 1'b0;
            end else begin
                rd_wait--;
            end
        end
        if (!rst) begin
            if (prev_stall && ({dn_wr, dn_rd, dn_addr, dn_be, dn_wdata} != prev_req)) hold_err++;
            if (dn_wr && dn_rd) both_err++;
            dn_ready   = slow ? ~dn_ready : 1'b1;
            prev_stall = (dn_wr || dn_rd) && !dn_ready;
            prev_req   = {dn_wr, dn_rd, dn_addr, dn_be, dn_wdata};
            if ((dn_wr || dn_rd) && dn_ready) begin
                if (log_n < 16) begin
                    log_addr[log_n] = dn_addr;
                    log_be[log_n]   = dn_be;
                    log_data[log_n] = dn_wdata;
                    log_wr[log_n]   = dn_wr;
                end
                log_n++;
                if (dn_rd) begin
                    rd_pend = 1'b1;
                    rd_wait = slow ? 2 : 0;
                    rd_addr = dn_addr;
                end
            end
        end
    end

    task automatic run_req(input bit wr, input logic [AW-1:0] addr, input logic [UB-1:0] be,
                           input logic [UW-1:0] wd, output int busy, output bit rv,
                           output logic [UW-1:0] rd);
        @(negedge clk);
        log_n    = 0;
        up_addr  = addr;
        up_be    = be;
        up_wdata = wd;
        up_wr    = wr;
        up_rd    = !wr;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_wr = 1'b0;
        up_rd = 1'b0;
        busy  = 0;
        while (!up_ready) begin
            busy++;
            @(negedge clk);
        end
        rv = up_rvalid;
        rd = up_rdata;
    endtask

    task automatic check_log(input bit wr, input logic [AW-1:0] addr, input logic [UB-1:0] be,
                             input logic [UW-1:0] wd);
        int            e = 0;
        logic [AW-1:0] base = addr & ~AW'(UB - 1);
        for (int c = 0; c < NCH; c++) begin
            if (be[c*DB +: DB] != '0) begin
                if (e < log_n && e < 16) begin
                    chk("R4 chunk address", log_addr[e], base + AW'(c * DB));
                    chk("R3 chunk byte enables", log_be[e], be[c*DB +: DB]);
                    chk("R7 access kind", log_wr[e], wr);
                    if (wr) chk("R2 chunk write data", log_data[e], wd[c*DW +: DW]);
                end
                e++;
            end
        end
        chk("R3 number of issued chunks", log_n, e);
    endtask

    task automatic t_reset;
        chk("R1 ready after reset", up_ready, 1);
        chk("R1 rvalid after reset", up_rvalid, 0);
        chk("R1 no downstream request", {dn_wr, dn_rd}, 0);
    endtask

    task automatic t_full_write;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(1, 32'h0000_1230, 8'hFF, 64'h1122_3344_5566_7788, busy, rv, rd);
        chk("R5 full write busy cycles", busy, 4);
        chk("R2 no read pulse on write", rv, 0);
        check_log(1, 32'h0000_1230, 8'hFF, 64'h1122_3344_5566_7788);
    endtask

    task automatic t_sparse_write;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(1, 32'h0000_2005, 8'b0100_0010, 64'hA1B2_C3D4_E5F6_0718, busy, rv, rd);
        chk("R5 sparse write busy cycles", busy, 2);
        check_log(1, 32'h0000_2005, 8'b0100_0010, 64'hA1B2_C3D4_E5F6_0718);
    endtask

    task automatic t_zero_write;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(1, 32'h0000_3000, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, busy, rv, rd);
        chk("R9 empty write keeps ready", busy, 0);
        chk("R9 empty write no traffic", log_n, 0);
        chk("R9 empty write no read pulse", rv, 0);
    endtask

    task automatic t_full_read;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(0, 32'h0000_4008, 8'hFF, '0, busy, rv, rd);
        chk("R5 full read busy cycles", busy, 8);
        chk("R8 read valid at completion", rv, 1);
        chk("R8 full read data", rd, exp_rd(32'h0000_4008, 8'hFF));
        check_log(0, 32'h0000_4008, 8'hFF, '0);
        @(negedge clk);
        chk("R8 read valid single cycle", up_rvalid, 0);
    endtask

    task automatic t_sparse_read;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(0, 32'h0000_50F7, 8'b0011_1000, '0, busy, rv, rd);
        chk("R5 sparse read busy cycles", busy, 4);
        chk("R8 sparse read valid", rv, 1);
        chk("R8 sparse read data with zeroed bytes", rd, exp_rd(32'h0000_50F7, 8'b0011_1000));
        check_log(0, 32'h0000_50F7, 8'b0011_1000, '0);
    endtask

    task automatic t_zero_read;
        int busy; bit rv; logic [UW-1:0] rd;
        run_req(0, 32'h0000_6000, 8'h00, '0, busy, rv, rd);
        chk("R10 empty read busy", busy, 0);
        chk("R10 empty read valid", rv, 1);
        chk("R10 empty read data", rd, 0);
        chk("R10 empty read no traffic", log_n, 0);
    endtask

    task automatic t_stalled;
        int busy; bit rv; logic [UW-1:0] rd;
        slow = 1'b1;
        run_req(1, 32'h0000_7010, 8'b1111_0001, 64'h0F1E_2D3C_4B5A_6978, busy, rv, rd);
        check_log(1, 32'h0000_7010, 8'b1111_0001, 64'h0F1E_2D3C_4B5A_6978);
        run_req(0, 32'h0000_7010, 8'b1100_0111, '0, busy, rv, rd);
        chk("R7 stalled read valid", rv, 1);
        chk("R8 stalled read data", rd, exp_rd(32'h0000_7010, 8'b1100_0111));
        check_log(0, 32'h0000_7010, 8'b1100_0111, '0);
        slow = 1'b0;
        chk("R6 request held during stall", hold_err, 0);
        chk("R7 read and write never together", both_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_sparse_write();
        t_zero_write();
        t_full_read();
        t_sparse_read();
        t_zero_read();
        t_stalled();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule